// File: doc/BRIEF.md
# Prioritized Interrupt Controller with In-Service Tracking

The block collects interrupt events from sixteen channels and presents them to a processor as one request line plus a vector. A rising edge on an enabled channel input latches into that channel's pending bit. Channel 15 has the highest priority and channel 0 the lowest. The request line is raised while some pending channel outranks every channel currently marked in service. When the processor answers with an acknowledge strobe, the block returns a vector for the winning channel in the next cycle. The vector is the upper nibble of a base value followed by the 4-bit channel number.

A global mode bit chooses how an acknowledged interrupt is retired. In automatic mode the acknowledge simply consumes the pending bit, and the in-service bits are held at zero. In software mode the acknowledge also marks the channel in service. That mark holds back every lower channel's request and vector until software clears it. Higher channels can still interrupt, which allows nesting.

A small byte-wide register bus gives read access to the pending, in-service, enable and configuration registers. Writes to pending and in-service can only clear bits.

Top module: `intc_prio_ctrl`

## Requirements
- R1: A 0-to-1 transition on `irq_in[i]` sets pending bit i at the next clock edge, but only while enable bit i is 1. A level held high sets the bit only once: after software clears it, it stays clear until a new rising edge arrives. Edges on a disabled channel are ignored.
- R2: Writing 0 to an enable bit clears that channel's pending bit at the same clock edge.
- R3: `irq_req` is 1 exactly when at least one pending channel has a higher number than every in-service channel. When nothing is in service, any pending channel is enough.
- R4: An acknowledge is taken when `ack_stb` is 1 at a clock edge while `irq_req` is 1. In the following cycle `vec_valid` is 1 and `vec_out` equals {configuration bits 7:4, winner number}. If `irq_req` is 0 at that edge, `vec_valid` stays 0 and no state changes.
- R5: In automatic mode (configuration bit 3 = 0), a taken acknowledge clears the winner's pending bit, and all in-service bits read 0.
- R6: In software mode (configuration bit 3 = 1), a taken acknowledge clears the winner's pending bit and sets its in-service bit.
- R7: While channel k is in service, events on lower channels still latch as pending but raise no request and win no acknowledge. A higher pending channel still requests and can be acknowledged, which nests its service above k.
- R8: A new event on a channel that is in service latches into its pending bit. It produces a request only after that channel's in-service bit has been cleared.
- R9: In a write to a pending or in-service register, each 0 bit clears the matching bit and each 1 bit leaves it unchanged. No write ever sets an in-service bit.
- R10: Writing configuration bit 3 to 0 clears every in-service bit at that clock edge.
- R11: Register map, where bit b of each channel register is channel 8+b (upper byte) or channel b (lower byte):
  - address 0 and address 1: pending, upper and lower byte;
  - address 2 and address 3: in-service, upper and lower byte;
  - address 4 and address 5: enable, upper and lower byte;
  - address 6: configuration, with the base value in bits 7:4, the mode in bit 3, and bits 2:0 reading 0;
  - address 7: reads 0.
  After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Channel event inputs, rising-edge sensitive |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ack_stb | input | 1 | Acknowledge strobe |
| irq_req | output | 1 | Interrupt request |
| vec_valid | output | 1 | Vector present, one cycle after a taken acknowledge |
| vec_out | output | 8 | Vector: base nibble and winner number |

## Verification
Arbitration is driven with one-hot patterns at both ends of the priority range, with patterns that mix bytes, and with all ones and all zeros. These tell whether the winner search crosses the byte boundary and whether it favours the top bit. An ack with nothing pending shows whether an empty acknowledge is really a no-op. A software-mode sequence then nests a higher channel over a lower one and re-fires the in-service channel. It retires the two channels in turn, which separates "blocked by in-service" from "blocked by pending". Held levels, disabled channels, and write masks with mixed ones and zeros show whether edge detection and the clear-only writes touch only the intended bits.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Index of the most significant set bit; 0 when none is set.
  function automatic int top_bit(input logic [31:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Channels strictly above idx; all channels when nothing blocks.
  function automatic logic [31:0] outrank_mask(input int idx, input logic blocked);
    logic [31:0] m;
    m = ~((32'd2 << idx) - 32'd1);
    return blocked ? m : '1;
  endfunction

  typedef enum logic [1:0] {
    RG_PEND = 2'd0,
    RG_SERV = 2'd1,
    RG_ENA  = 2'd2,
    RG_CFG  = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/intc_edge_bank.sv
module intc_edge_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  output logic [NUM_CH-1:0] rise
);
  logic [NUM_CH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  assign rise = irq_in & ~prev_q;
endmodule

// File: rtl/intc_chan_state.sv
module intc_chan_state #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] rise,
  input  logic [NUM_CH-1:0] ena_q,
  input  logic [NUM_CH-1:0] ena_d,
  input  logic [NUM_CH-1:0] pend_keep,
  input  logic [NUM_CH-1:0] svc_keep,
  input  logic [NUM_CH-1:0] ack_set,
  input  logic              sw_mode_d,
  output logic [NUM_CH-1:0] pend_q,
  output logic [NUM_CH-1:0] svc_q
);
  logic [NUM_CH-1:0] pend_d, svc_d, new_evt;

  assign new_evt = rise & ena_q;

  always_comb begin
    pend_d = ((pend_q & pend_keep & ~ack_set) | new_evt) & ena_d;
    svc_d  = sw_mode_d ? ((svc_q & svc_keep) | ack_set) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_set)); // R4
  AST_DISABLED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ena_q) == '0); // R2
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_set) |=> (pend_q & $past(ack_set & ~new_evt)) == '0); // R5
  AST_SW_ACK_SETS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode_d && (|ack_set)) |=> (svc_q & $past(ack_set)) == $past(ack_set)); // R6
  AST_SERVICE_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (svc_q & ~$past(svc_q) & ~$past(ack_set)) == '0); // R9
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
  import intc_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] svc,
  output logic              req,
  output logic [IDX_W-1:0]  win_idx
);
  logic              svc_any;
  logic [IDX_W-1:0]  svc_idx;
  logic [NUM_CH-1:0] eligible;

  always_comb begin
    svc_any  = |svc;
    svc_idx  = IDX_W'(top_bit(32'(svc)));
    eligible = pend & NUM_CH'(outrank_mask(int'(svc_idx), svc_any));
    req      = |eligible;
    win_idx  = IDX_W'(top_bit(32'(eligible)));
  end
endmodule

// File: rtl/intc_prio_ctrl.sv
module intc_prio_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 8,
  localparam int NGRP   = NUM_CH / DATA_W,
  localparam int ADDR_W = $clog2(3 * NGRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ack_stb,
  output logic              irq_req,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_out
);
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int BASE_W   = DATA_W - IDX_W;
  localparam int MODE_BIT = IDX_W - 1;
  localparam int CFG_ADDR = 3 * NGRP;

  logic [NUM_CH-1:0] rise, pend_q, svc_q, ena_q, ena_d;
  logic [NUM_CH-1:0] pend_keep, svc_keep, ack_set;
  logic [BASE_W-1:0] base_q, base_d;
  logic              sw_mode_q, sw_mode_d;
  logic [IDX_W-1:0]  win_idx;
  logic              ack_take;
  logic [DATA_W-1:0] vec_q;
  logic              vec_v_q;

  // Address of register kind k, byte group g (upper group first).
  function automatic logic [ADDR_W-1:0] reg_addr(input reg_kind_e k, input int g);
    return ADDR_W'(int'(k) * NGRP + (NGRP - 1 - g));
  endfunction

  intc_edge_bank #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rise(rise)
  );

  intc_chan_state #(.NUM_CH(NUM_CH)) u_state (
    .clk(clk), .rst_n(rst_n), .rise(rise), .ena_q(ena_q), .ena_d(ena_d),
    .pend_keep(pend_keep), .svc_keep(svc_keep), .ack_set(ack_set),
    .sw_mode_d(sw_mode_d), .pend_q(pend_q), .svc_q(svc_q)
  );

  intc_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .pend(pend_q), .svc(svc_q), .req(irq_req), .win_idx(win_idx)
  );

  // Write decode: clear masks and next values of the control registers
  always_comb begin
    ena_d     = ena_q;
    pend_keep = '1;
    svc_keep  = '1;
    base_d    = base_q;
    sw_mode_d = sw_mode_q;
    if (bus_wr) begin
      for (int g = 0; g < NGRP; g++) begin
        if (bus_addr == reg_addr(RG_PEND, g)) pend_keep[g*DATA_W +: DATA_W] = bus_wdata;
        if (bus_addr == reg_addr(RG_SERV, g)) svc_keep[g*DATA_W +: DATA_W]  = bus_wdata;
        if (bus_addr == reg_addr(RG_ENA, g))  ena_d[g*DATA_W +: DATA_W]     = bus_wdata;
      end
      if (bus_addr == ADDR_W'(CFG_ADDR)) begin
        base_d    = bus_wdata[DATA_W-1 -: BASE_W];
        sw_mode_d = bus_wdata[MODE_BIT];
      end
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (bus_addr == reg_addr(RG_PEND, g)) bus_rdata = pend_q[g*DATA_W +: DATA_W];
      if (bus_addr == reg_addr(RG_SERV, g)) bus_rdata = svc_q[g*DATA_W +: DATA_W];
      if (bus_addr == reg_addr(RG_ENA, g))  bus_rdata = ena_q[g*DATA_W +: DATA_W];
    end
    if (bus_addr == ADDR_W'(CFG_ADDR))
      bus_rdata = {base_q, sw_mode_q, {MODE_BIT{1'b0}}};
  end

  assign ack_take = ack_stb && irq_req;
  assign ack_set  = ack_take ? (NUM_CH'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q     <= '0;
      base_q    <= '0;
      sw_mode_q <= 1'b0;
      vec_q     <= '0;
      vec_v_q   <= 1'b0;
    end else begin
      ena_q     <= ena_d;
      base_q    <= base_d;
      sw_mode_q <= sw_mode_d;
      vec_v_q   <= ack_take;
      if (ack_take) vec_q <= {base_q, win_idx};
    end
  end

  assign vec_valid = vec_v_q;
  assign vec_out   = vec_q;

  AST_REQ_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend_q[win_idx]); // R3
  AST_REQ_OUTRANKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (svc_q >> win_idx) == '0); // R7
  AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_stb)); // R4
  AST_AUTO_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode_q |-> svc_q == '0); // R10
endmodule

// File: tb/test_intc_prio_ctrl.sv
module test_intc_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ack_stb = 1'b0;
  logic        irq_req, vec_valid;
  logic [7:0]  vec_out;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  intc_prio_ctrl i_intc_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_stb(ack_stb), .irq_req(irq_req), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // {pattern[15:0], expect request, expected winner[3:0]}
  localparam logic [20:0] VECS [9] = '{
    {16'h0001, 1'b1, 4'd0},
    {16'h8000, 1'b1, 4'd15},
    {16'h8001, 1'b1, 4'd15},
    {16'h00F0, 1'b1, 4'd7},
    {16'h0300, 1'b1, 4'd9},
    {16'hFFFF, 1'b1, 4'd15},
    {16'h0000, 1'b0, 4'd0},
    {16'h1234, 1'b1, 4'd12},
    {16'h0180, 1'b1, 4'd8}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk);
    irq_in = p;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    ack_stb = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state and map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R11 reset read", d, 8'h00);
    end
    chk("R11 reset req", irq_req, 1'b0);
    chk("R11 reset vec_valid", vec_valid, 1'b0);

    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h50);
    rd(3'd4, d); chk("R11 enable hi read", d, 8'hFF);
    rd(3'd6, d); chk("R11 cfg read", d, 8'h50);

    // Table: automatic mode arbitration (R3 R4 R5)
    for (int k = 0; k < 9; k++) begin
      logic [15:0] pat, left;
      logic        ereq;
      logic [3:0]  ewin;
      {pat, ereq, ewin} = VECS[k];
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      pulse(pat);
      chk("R3 request", irq_req, ereq);
      rd(3'd0, d); rd(3'd1, d2);
      chk("R1 pending latched", {d, d2}, pat);
      ack();
      chk("R4 vec_valid", vec_valid, ereq);
      if (ereq) chk("R4 vector", vec_out, {4'h5, ewin});
      left = ereq ? (pat & ~(16'd1 << ewin)) : pat;
      rd(3'd0, d); rd(3'd1, d2);
      chk("R5 pending after ack", {d, d2}, left);
      rd(3'd3, d);
      chk("R5 no service in auto", d, 8'h00);
    end

    // Software mode nesting (R6 R7 R8 R9 R10)
    wr(3'd6, 8'hA8);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    pulse(16'h0020);
    ack();
    chk("R6 vector ch5", vec_out, 8'hA5);
    rd(3'd3, d); chk("R6 in-service ch5", d, 8'h20);
    rd(3'd1, d); chk("R6 pending cleared", d, 8'h00);
    chk("R6 req idle", irq_req, 1'b0);

    pulse(16'h0008);
    rd(3'd1, d); chk("R7 lower latches", d, 8'h08);
    chk("R7 lower blocked", irq_req, 1'b0);
    ack();
    chk("R4 empty ack", vec_valid, 1'b0);
    rd(3'd1, d); chk("R4 empty ack keeps pending", d, 8'h08);

    pulse(16'h0020);
    rd(3'd1, d); chk("R8 second event latched", d, 8'h28);
    chk("R8 no request while in service", irq_req, 1'b0);

    pulse(16'h0200);
    chk("R7 higher requests", irq_req, 1'b1);
    ack();
    chk("R7 nested vector", vec_out, 8'hA9);
    rd(3'd2, d); chk("R7 nested in-service", d, 8'h02);
    chk("R7 req after nest", irq_req, 1'b0);

    wr(3'd2, 8'hFD);
    rd(3'd2, d); chk("R9 clear ch9", d, 8'h00);
    chk("R8 still blocked by ch5", irq_req, 1'b0);
    wr(3'd3, 8'hDF);
    rd(3'd3, d); chk("R9 clear ch5", d, 8'h00);
    chk("R8 request after clear", irq_req, 1'b1);
    ack();
    chk("R8 vector second event", vec_out, 8'hA5);
    rd(3'd1, d); chk("R8 pending left", d, 8'h08);

    wr(3'd3, 8'hFF);
    rd(3'd3, d); chk("R9 ones keep service", d, 8'h20);
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R9 write cannot set", d, 8'h00);
    pulse(16'h0003);
    wr(3'd1, 8'hFD);
    rd(3'd1, d); chk("R9 pending clear one bit", d, 8'h09);

    wr(3'd6, 8'hA0);
    rd(3'd3, d); chk("R10 auto clears service", d, 8'h00);
    chk("R10 request resumes", irq_req, 1'b1);
    ack();
    chk("R5 vector ch3", vec_out, 8'hA3);
    rd(3'd3, d); chk("R5 service stays clear", d, 8'h00);
    rd(3'd1, d); chk("R5 pending after ack", d, 8'h01);

    // R2: disable clears pending; R1: disabled edges ignored
    wr(3'd5, 8'hFE);
    rd(3'd1, d); chk("R2 disable clears", d, 8'h00);
    pulse(16'h0001);
    rd(3'd1, d); chk("R1 disabled edge ignored", d, 8'h00);
    chk("R1 disabled no request", irq_req, 1'b0);
    wr(3'd5, 8'hFF);

    // R1: held level sets once
    @(negedge clk);
    irq_in = 16'h0004;
    repeat (2) @(negedge clk);
    rd(3'd1, d); chk("R1 level sets", d, 8'h04);
    wr(3'd1, 8'hFB);
    repeat (3) @(negedge clk);
    rd(3'd1, d); chk("R1 held level no re-set", d, 8'h00);
    irq_in = '0;
    @(negedge clk);

    finish_run();
  end
endmodule